// File: doc/BRIEF.md
# Comma-Delimited Record Framer

This block turns a stream of fixed 24-bit data records into the symbol stream that feeds an 8b/10b encoder on a serial readout link. Each output symbol is one byte plus a flag that marks it as a control character. The block releases one symbol every ten clock cycles. The clock runs at the serial bit rate, so one encoded symbol fills exactly ten bit times. Between symbol times the output holds still.

Records enter through a valid/ready handshake. When at least one record is waiting, the block opens a frame with a start comma. It then sends each record as three plain bytes, most significant byte first. The frame closes with an end comma when no record is waiting at a record boundary, or when the frame has carried its configured maximum number of records. While no frame is open, the link carries the idle comma. If a record is still waiting when a frame closes because of the limit, a new frame opens on the very next symbol.

The control-character values match the 8b/10b comma codes. K.28.7 (0xFC) opens a frame, K.28.5 (0xBC) closes it, and K.28.1 (0x3C) fills idle time.

Top module: `frame_builder`

## Requirements
- R1: Outside a frame, and from reset onwards, the output symbol is the idle comma: byte 0x3C with `tx_k` = 1.
- R2: A new symbol appears every BYTE_CYCLES clocks (10 by default). `tx_stb` is high for exactly the first cycle of each symbol, and `tx_byte`/`tx_k` do not change in any cycle where `tx_stb` is low.
- R3: A frame opens with the start comma (byte 0xFC, `tx_k` = 1). The start comma is only sent when `rec_valid` was high at the symbol boundary that emits it.
- R4: Each record is sent as three consecutive symbols with `tx_k` = 0: bits 23:16 first, then bits 15:8, then bits 7:0.
- R5: When no record is valid at a record boundary inside a frame, the next symbol is the end comma (byte 0xBC, `tx_k` = 1), followed by idle commas.
- R6: A frame carries at most `cfg_max_recs` records and then closes with the end comma. A value of 0 is treated as 1. `cfg_max_recs` is changed only while no frame is open.
- R7: When a frame closes on its limit and a record is still waiting, the symbol after the end comma is a start comma, with no idle comma between them.
- R8: `rec_ready` is high for a single cycle, and only in the last cycle before a symbol boundary at which the first byte of a record may be sent. A record is accepted when `rec_valid` and `rec_ready` are both high at a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_max_recs | input | CNT_W | Maximum records per frame (0 means 1) |
| rec_valid | input | 1 | A record is offered on `rec_data` |
| rec_data | input | REC_W | 24-bit record, held until accepted |
| rec_ready | output | 1 | Record is taken at this edge if valid |
| tx_byte | output | 8 | Symbol byte for the encoder |
| tx_k | output | 1 | Symbol is a control character |
| tx_stb | output | 1 | First cycle of a new symbol |

## Verification
Each scenario sends records with distinct byte values, so that a swapped byte order or a lost record shows up in the stream.

- A single record isolates the basic start, body and end sequence, and shows that the frame closes when the queue runs dry.
- A burst that stays under the limit shows that records follow each other with no comma between them.
- A burst that exceeds the limit tells a limit-driven close from an empty-queue close, and shows the end comma followed directly by a start comma.
- A limit of zero checks that it is treated as one.
- A long stretch with no records offered checks that a start comma never appears on its own.

A monitor running throughout checks the ten-cycle symbol spacing, output stability between strobes, and the placement of `rec_ready`.

// File: rtl/frame_pkg.sv
package frame_pkg;
  localparam logic [7:0] SYM_SOF  = 8'hFC; // K.28.7
  localparam logic [7:0] SYM_EOF  = 8'hBC; // K.28.5
  localparam logic [7:0] SYM_IDLE = 8'h3C; // K.28.1

  typedef enum logic [1:0] {
    ST_LINK, // between frames: last symbol idle or end comma
    ST_GAP,  // inside frame at a record boundary
    ST_BODY  // inside frame in the middle of a record
  } frm_state_t;
endpackage

// File: rtl/byte_tick_gen.sv
module byte_tick_gen #(
  parameter int BYTE_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (BYTE_CYCLES > 1) ? $clog2(BYTE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTE_CYCLES - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)              phase <= '0;
    else if (phase == LAST)  phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);

  generate
    if (BYTE_CYCLES > 1) begin : g_sparse
      // R2: symbol boundaries never fall on adjacent cycles
      assert_tick_sparse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import frame_pkg::*;
#(
  parameter int REC_W = 24,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cfg_max,
  input  logic             rec_valid,
  input  logic [REC_W-1:0] rec_data,
  output logic             rec_ready,
  output logic [7:0]       sym_byte,
  output logic             sym_k
);
  localparam int NB = REC_W / 8;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

  // Effective record limit: zero counts as one.
  function automatic logic [CNT_W-1:0] limit_of(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction

  // Byte i of a record, counting from the most significant end.
  function automatic logic [7:0] pick_byte(input logic [REC_W-1:0] d,
                                           input logic [IW-1:0] i);
    logic [REC_W-1:0] s;
    s = d >> (REC_W - 8 - 8 * int'(i));
    return s[7:0];
  endfunction

  frm_state_t       st;
  logic [IW-1:0]    idx;
  logic [CNT_W-1:0] cnt;
  logic [REC_W-1:0] hold;
  logic [CNT_W-1:0] lim;
  logic             room;
  logic             take;

  assign lim       = limit_of(cfg_max);
  assign room      = (cnt < lim);
  assign rec_ready = tick && (st == ST_GAP) && room;
  assign take      = rec_ready && rec_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_LINK;
      idx      <= '0;
      cnt      <= '0;
      hold     <= '0;
      sym_byte <= SYM_IDLE;
      sym_k    <= 1'b1;
    end else if (tick) begin
      unique case (st)
        ST_LINK: begin
          if (rec_valid) begin
            sym_byte <= SYM_SOF;
            sym_k    <= 1'b1;
            cnt      <= '0;
            st       <= ST_GAP;
          end else begin
            sym_byte <= SYM_IDLE;
            sym_k    <= 1'b1;
          end
        end
        ST_GAP: begin
          if (take) begin
            sym_byte <= pick_byte(rec_data, '0);
            sym_k    <= 1'b0;
            hold     <= rec_data;
            cnt      <= cnt + 1'b1;
            idx      <= IW'(1);
            st       <= (NB > 1) ? ST_BODY : ST_GAP;
          end else begin
            sym_byte <= SYM_EOF;
            sym_k    <= 1'b1;
            cnt      <= '0;
            st       <= ST_LINK;
          end
        end
        ST_BODY: begin
          sym_byte <= pick_byte(hold, idx);
          sym_k    <= 1'b0;
          if (idx == LAST_IDX) st <= ST_GAP;
          else                 idx <= idx + 1'b1;
        end
        default: st <= ST_LINK;
      endcase
    end
  end

  // R8: ready is only raised in the cycle before a symbol boundary
  assert_ready_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ready |-> tick);

  // R4: while inside a record, the symbol just sent is a data byte
  assert_body_is_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BODY) |-> !sym_k);

  // R6: the record count in a frame never exceeds the limit
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);

  // R1: between frames the symbol is always a control character
  assert_link_is_comma_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LINK) |-> sym_k);
endmodule

// File: rtl/frame_builder.sv
module frame_builder
  import frame_pkg::*;
#(
  parameter int REC_W       = 24,
  parameter int CNT_W       = 4,
  parameter int BYTE_CYCLES = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_max_recs,
  input  logic             rec_valid,
  input  logic [REC_W-1:0] rec_data,
  output logic             rec_ready,
  output logic [7:0]       tx_byte,
  output logic             tx_k,
  output logic             tx_stb
);
  logic tick;

  byte_tick_gen #(.BYTE_CYCLES(BYTE_CYCLES)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  frame_sequencer #(.REC_W(REC_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cfg_max  (cfg_max_recs),
    .rec_valid(rec_valid),
    .rec_data (rec_data),
    .rec_ready(rec_ready),
    .sym_byte (tx_byte),
    .sym_k    (tx_k)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tx_stb <= 1'b0;
    else        tx_stb <= tick;
  end

  // R2: the symbol only changes together with its strobe
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_stb |-> $stable({tx_k, tx_byte}));

  // R3: a start comma is only emitted when a record was offered
  assert_sof_needs_record_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stb && tx_k && tx_byte == SYM_SOF) |-> $past(rec_valid));
endmodule

// File: tb/test_frame_builder.sv
module test_frame_builder;
  localparam logic [8:0] S_SOF  = {1'b1, 8'hFC};
  localparam logic [8:0] S_EOF  = {1'b1, 8'hBC};
  localparam logic [8:0] S_IDLE = {1'b1, 8'h3C};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_max_recs = 4'd4;
  logic        rec_valid = 1'b0;
  logic [23:0] rec_data = '0;
  logic        rec_ready;
  logic [7:0]  tx_byte;
  logic        tx_k;
  logic        tx_stb;

  frame_builder i_frame_builder (
    .clk(clk), .rst_n(rst_n), .cfg_max_recs(cfg_max_recs),
    .rec_valid(rec_valid), .rec_data(rec_data), .rec_ready(rec_ready),
    .tx_byte(tx_byte), .tx_k(tx_k), .tx_stb(tx_stb)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [8:0] syms [0:4095];
  int n_sym = 0;
  logic [8:0] expq [$];

  // Continuous monitor
  int cyc = 0, last_stb = -1, gap_err = 0, hold_err = 0, rdy_err = 0;
  logic [8:0] prev_sym = S_IDLE;
  logic prev_rdy = 1'b0;
  bit mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (tx_stb) begin
        if (last_stb >= 0 && cyc - last_stb != 10) gap_err++;
        last_stb = cyc;
        if (n_sym < 4096) syms[n_sym] = {tx_k, tx_byte};
        n_sym++;
      end else if ({tx_k, tx_byte} != prev_sym) hold_err++;
      if (prev_rdy && !tx_stb) rdy_err++;
      if (prev_rdy && rec_ready) rdy_err++;
      prev_sym = {tx_k, tx_byte};
      prev_rdy = rec_ready;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [23:0] d);
    rec_data  = d;
    rec_valid = 1'b1;
    @(negedge clk);
    while (!rec_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic wait_syms(input int n);
    repeat (n * 10) @(negedge clk);
  endtask

  task automatic add_rec(input logic [23:0] d);
    expq.push_back({1'b0, d[23:16]});
    expq.push_back({1'b0, d[15:8]});
    expq.push_back({1'b0, d[7:0]});
  endtask

  // Compare the symbols after mark against expq, then require idle (R1).
  task automatic check_seq(input int mark, input string req);
    int first = -1;
    bit idle_ok = 1'b1;
    for (int i = mark; i < n_sym; i++) begin
      if (syms[i] != S_IDLE) begin first = i; break; end
    end
    check(first >= 0, req, 32'(first), 32'(mark));
    if (first < 0) return;
    for (int j = 0; j < expq.size(); j++)
      check(syms[first + j] == expq[j], req, 32'(syms[first + j]), 32'(expq[j]));
    for (int j = first + expq.size(); j < n_sym; j++)
      if (syms[j] != S_IDLE) idle_ok = 1'b0;
    check(idle_ok, "R1 idle after frame", 32'(idle_ok), 32'd1);
    expq.delete();
  endtask

  task automatic t_reset;
    @(negedge clk);
    check({tx_k, tx_byte} == S_IDLE, "R1 reset symbol", 32'({tx_k, tx_byte}), 32'(S_IDLE));
    check(rec_ready == 1'b0, "R8 reset ready", 32'(rec_ready), 32'd0);
    check(tx_stb == 1'b0, "R2 reset strobe", 32'(tx_stb), 32'd0);
  endtask

  task automatic t_idle;
    int mark = n_sym;
    bit ok = 1'b1;
    wait_syms(20);
    for (int i = mark; i < n_sym; i++) if (syms[i] != S_IDLE) ok = 1'b0;
    check(ok, "R3 no start comma without a record", 32'(ok), 32'd1);
    check(n_sym - mark >= 19, "R2 symbol rate", 32'(n_sym - mark), 32'd20);
  endtask

  task automatic t_single;
    int mark = n_sym;
    cfg_max_recs = 4'd4;
    push(24'hA1B2C3);
    rec_valid = 1'b0;
    wait_syms(8);
    expq.push_back(S_SOF); add_rec(24'hA1B2C3); expq.push_back(S_EOF);
    check_seq(mark, "R4 R5 single record");
  endtask

  task automatic t_burst;
    int mark = n_sym;
    cfg_max_recs = 4'd8;
    push(24'h112233); push(24'h445566); push(24'h778899);
    rec_valid = 1'b0;
    wait_syms(8);
    expq.push_back(S_SOF);
    add_rec(24'h112233); add_rec(24'h445566); add_rec(24'h778899);
    expq.push_back(S_EOF);
    check_seq(mark, "R4 R5 burst under limit");
  endtask

  task automatic t_limit;
    int mark = n_sym;
    cfg_max_recs = 4'd2;
    push(24'h010203); push(24'h040506); push(24'h070809);
    push(24'h0A0B0C); push(24'h0D0E0F);
    rec_valid = 1'b0;
    wait_syms(8);
    expq.push_back(S_SOF); add_rec(24'h010203); add_rec(24'h040506); expq.push_back(S_EOF);
    expq.push_back(S_SOF); add_rec(24'h070809); add_rec(24'h0A0B0C); expq.push_back(S_EOF);
    expq.push_back(S_SOF); add_rec(24'h0D0E0F); expq.push_back(S_EOF);
    check_seq(mark, "R6 R7 limit of two");
  endtask

  task automatic t_zero;
    int mark = n_sym;
    cfg_max_recs = 4'd0;
    push(24'hDEAD01); push(24'hBEEF02);
    rec_valid = 1'b0;
    wait_syms(8);
    expq.push_back(S_SOF); add_rec(24'hDEAD01); expq.push_back(S_EOF);
    expq.push_back(S_SOF); add_rec(24'hBEEF02); expq.push_back(S_EOF);
    check_seq(mark, "R6 R7 zero limit acts as one");
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    t_reset();
    t_idle();
    t_single();
    t_burst();
    t_limit();
    t_zero();
    check(gap_err == 0, "R2 strobe spacing", 32'(gap_err), 32'd0);
    check(hold_err == 0, "R2 hold between strobes", 32'(hold_err), 32'd0);
    check(rdy_err == 0, "R8 ready placement", 32'(rdy_err), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule